// File: doc/BRIEF.md
# SRAM Bank Matrix

This block is a small multi-layer interconnect that sits between four AHB-Lite style masters and three on-chip SRAM banks. The masters are an instruction-fetch port (master 0), a data-load/store port (master 1), a system port (master 2) and a DMA port (master 3). Every bank has its own arbiter and memory port. Masters that target different banks therefore move in the same cycle, and only masters that meet on one bank wait for each other.

The three banks are placed back to back from a base address, with sizes set by parameters. Software sees one linear RAM with no holes. The bank boundaries come from the cumulative sizes. A fixed path map sets which master may reach which bank. A transfer on a path that does not exist, outside the RAM, or wider than the data bus receives a two-cycle ERROR response and never touches memory.

Each accepted transfer is held inside the block until its bank serves it. The master's data phase runs with HREADY low until then. A served transfer completes in the cycle after its grant.

Top module: `sram_bank_xbar`

## Requirements
- R1: During and straight after reset every master sees HREADY high and HRESP low.
- R2: The address decode is contiguous. Offsets from the base below BANK0_BYTES select bank 0. Offsets below BANK0_BYTES+BANK1_BYTES select bank 1. Offsets below the sum of all three sizes select bank 2. Each word keeps its own data across the bank edges.
- R3: The path map is fixed. Bank 0 is reachable by masters 0, 1 and 3. Banks 1 and 2 are reachable by masters 2 and 3. A transfer on any other path leaves memory unchanged.
- R4: These transfers get an ERROR response: a disallowed path, an address below the base or at or beyond base plus the total size, or HSIZE above 2. The response is one cycle with HREADY low and HRESP high, then one cycle with HREADY high and HRESP high.
- R5: A transfer with no competition completes with exactly one wait state. HREADY is low in the first data-phase cycle and high in the second.
- R6: Masters addressing different banks in the same cycle do not stall each other. Each completes with one wait state.
- R7: Each bank grants one transfer per cycle. The grant is round-robin and starts at the master after the one last granted on that bank. After reset, master 0 has first turn.
- R8: A waiting master holds HREADY low until its bank grants it. It completes in the cycle after the grant. Every accepted transfer is performed exactly once.
- R9: Byte and halfword writes (HSIZE 0 and 1) change only the little-endian byte lanes picked by the low address bits. Data is taken from those lanes of HWDATA.
- R10: Successful transfers complete with HRESP low. A read returns the full addressed word on HRDATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_haddr | input | NM*AW | Byte address per master, master m at bits m*AW upward |
| m_htrans | input | NM*2 | Transfer type per master, bit 1 set means a transfer |
| m_hwrite | input | NM | Write when high |
| m_hsize | input | NM*3 | Transfer size per master, log2 of bytes |
| m_hwdata | input | NM*DW | Write data per master, valid in the data phase |
| m_hrdata | output | NM*DW | Read data per master, valid when HREADY closes a read |
| m_hready | output | NM | Transfer done / stall indication per master |
| m_hresp | output | NM | Error response per master |

## Verification
The assertions assume that masters behave as AHB-Lite masters. A master offers a new address only while its own HREADY is high. It holds HWDATA stable for the whole data phase. It drives no X onto HTRANS. The bench drives every master through one transfer task. That task presents the address phase once, goes idle at the next negative edge, and keeps the write data steady until HREADY returns, so parallel and contending traffic stays within those rules.

// File: rtl/sram_bank_xbar.sv
module sram_bank_xbar #(
  parameter int NM = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] BASE = 32'h2000_0000,
  parameter int BANK0_BYTES = 256,
  parameter int BANK1_BYTES = 128,
  parameter int BANK2_BYTES = 128,
  parameter logic [NM*3-1:0] PATH_MAP = 12'hF89
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM*AW-1:0] m_haddr,
  input  logic [NM*2-1:0]  m_htrans,
  input  logic [NM-1:0]    m_hwrite,
  input  logic [NM*3-1:0]  m_hsize,
  input  logic [NM*DW-1:0] m_hwdata,
  output logic [NM*DW-1:0] m_hrdata,
  output logic [NM-1:0]    m_hready,
  output logic [NM-1:0]    m_hresp
);
  localparam int NB = 3;
  localparam int LN = DW / 8;
  localparam int LL = $clog2(LN);
  localparam int BW = $clog2(NB);
  localparam int MW = $clog2(NM);
  localparam logic [AW-1:0] EDGE1 = AW'(BANK0_BYTES);
  localparam logic [AW-1:0] EDGE2 = AW'(BANK0_BYTES + BANK1_BYTES);
  localparam logic [AW-1:0] SPAN  = AW'(BANK0_BYTES + BANK1_BYTES + BANK2_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_DONE, S_ERR1, S_ERR2} mst_t;

  function automatic logic [LN-1:0] lanes(input logic [2:0] sz, input logic [AW-1:0] off);
    int n, s;
    n = 1 << sz;
    s = int'(off[LL-1:0]) & ~(n - 1);
    return LN'(((1 << n) - 1) << s);
  endfunction

  mst_t            st     [NM];
  logic [AW-1:0]   q_off  [NM];
  logic [BW-1:0]   q_bank [NM];
  logic [2:0]      q_size [NM];
  logic [NM-1:0]   q_wr;
  logic [AW-1:0]   d_off  [NM];
  logic [BW-1:0]   d_bank [NM];
  logic [NM-1:0]   d_ok, take, won;
  logic [NB*NM-1:0] bank_gnt;
  logic [NB*DW-1:0] bank_rd;

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      logic [AW-1:0] a, off;
      a = m_haddr[m*AW +: AW];
      off = a - BASE;
      d_bank[m] = (off < EDGE1) ? BW'(0) : (off < EDGE2) ? BW'(1) : BW'(2);
      d_off[m]  = off - ((d_bank[m] == BW'(0)) ? '0 : (d_bank[m] == BW'(1)) ? EDGE1 : EDGE2);
      d_ok[m]   = (a >= BASE) && (off < SPAN) && PATH_MAP[m*NB + int'(d_bank[m])]
                  && (int'(m_hsize[m*3 +: 3]) <= LL);
      take[m]   = (m_htrans[m*2 +: 2] inside {2'b10, 2'b11}) && m_hready[m];
      won[m]    = 1'b0;
      for (int b = 0; b < NB; b++) won[m] = won[m] | bank_gnt[b*NM + m];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NM; m++) begin
        st[m] <= S_IDLE;
        q_off[m] <= '0;
        q_bank[m] <= '0;
        q_size[m] <= '0;
      end
      q_wr <= '0;
    end else begin
      for (int m = 0; m < NM; m++) begin
        case (st[m])
          S_WAIT: if (won[m]) st[m] <= S_DONE;
          S_ERR1: st[m] <= S_ERR2;
          default:
            if (take[m]) begin
              st[m]     <= d_ok[m] ? S_WAIT : S_ERR1;
              q_off[m]  <= d_off[m];
              q_bank[m] <= d_bank[m];
              q_size[m] <= m_hsize[m*3 +: 3];
              q_wr[m]   <= m_hwrite[m];
            end else begin
              st[m] <= S_IDLE;
            end
        endcase
      end
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_port
    assign m_hready[m] = (st[m] == S_IDLE) || (st[m] == S_DONE) || (st[m] == S_ERR2);
    assign m_hresp[m]  = (st[m] == S_ERR1) || (st[m] == S_ERR2);
    assign m_hrdata[m*DW +: DW] = (st[m] == S_DONE && !q_wr[m])
                                  ? bank_rd[int'(q_bank[m])*DW +: DW] : '0;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int DEP = ((b == 0) ? BANK0_BYTES : (b == 1) ? BANK1_BYTES : BANK2_BYTES) / LN;
    localparam int IW  = $clog2(DEP);

    logic [MW-1:0] ptr, pick;
    logic          hit;
    logic [DW-1:0] mem [DEP];
    logic [DW-1:0] rd;
    logic [IW-1:0] w_idx;
    logic [LN-1:0] w_mask;
    logic [DW-1:0] w_data;

    always_comb begin
      hit  = 1'b0;
      pick = ptr;
      for (int k = 1; k <= NM; k++) begin
        int c;
        c = (int'(ptr) + k) % NM;
        if (!hit && st[c] == S_WAIT && int'(q_bank[c]) == b) begin
          hit  = 1'b1;
          pick = MW'(c);
        end
      end
    end

    for (genvar m = 0; m < NM; m++) begin : g_gnt
      assign bank_gnt[b*NM + m] = hit && (pick == MW'(m));
    end

    assign w_idx  = IW'(q_off[pick] >> LL);
    assign w_mask = lanes(q_size[pick], q_off[pick]);
    assign w_data = m_hwdata[int'(pick)*DW +: DW];

    always_ff @(posedge clk) begin
      if (hit) begin
        if (q_wr[pick]) begin
          for (int i = 0; i < LN; i++)
            if (w_mask[i]) mem[w_idx][i*8 +: 8] <= w_data[i*8 +: 8];
        end else begin
          rd <= mem[w_idx];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= MW'(NM - 1);
      else if (hit) ptr <= pick;
    end

    assign bank_rd[b*DW +: DW] = rd;
  end
endmodule

// File: rtl/sram_bank_xbar_chk.sv
module sram_bank_xbar_chk #(
  parameter int NM = 4,
  parameter int NB = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NM-1:0]   hready,
  input logic [NM-1:0]   hresp,
  input logic [NB*NM-1:0] gnt,
  input logic [NM*NB-1:0] path
);
  for (genvar m = 0; m < NM; m++) begin : g_m
    logic [7:0] wcnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wcnt <= '0;
      else wcnt <= (!hready[m] && !hresp[m]) ? wcnt + 8'd1 : 8'd0;
    end

    p_err_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp[m] && !hready[m]) |=> (hresp[m] && hready[m]));
    p_err_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hresp[m]) |-> !hready[m]);
    p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt <= 8'(NM));

    for (genvar b = 0; b < NB; b++) begin : g_b
      p_gnt_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[b*NM + m] |-> path[m*NB + b]);
      p_gnt_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[b*NM + m] |=> (hready[m] && !hresp[m]));
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_one
    p_gnt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[b*NM +: NM]));
  end
endmodule

bind sram_bank_xbar sram_bank_xbar_chk #(.NM(NM), .NB(3)) u_chk (
  .clk(clk), .rst_n(rst_n), .hready(m_hready), .hresp(m_hresp),
  .gnt(bank_gnt), .path(PATH_MAP)
);

// File: tb/sram_bank_xbar_tb.sv
`timescale 1ns/1ps
module sram_bank_xbar_tb;
  localparam logic [31:0] B = 32'h2000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a_r [4];
  logic [1:0]  t_r [4];
  logic        w_r [4];
  logic [2:0]  s_r [4];
  logic [31:0] d_r [4];

  logic [127:0] haddr, hwdata, hrdata;
  logic [7:0]   htrans;
  logic [3:0]   hwrite, hready, hresp;
  logic [11:0]  hsize;

  for (genvar g = 0; g < 4; g++) begin : g_drv
    assign haddr[g*32 +: 32]  = a_r[g];
    assign htrans[g*2 +: 2]   = t_r[g];
    assign hwrite[g]          = w_r[g];
    assign hsize[g*3 +: 3]    = s_r[g];
    assign hwdata[g*32 +: 32] = d_r[g];
  end

  sram_bank_xbar u_dut (
    .clk(clk), .rst_n(rst_n), .m_haddr(haddr), .m_htrans(htrans), .m_hwrite(hwrite),
    .m_hsize(hsize), .m_hwdata(hwdata), .m_hrdata(hrdata), .m_hready(hready), .m_hresp(hresp)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input int m, input logic [31:0] addr, input bit wr, input logic [2:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output int waits,
                      output bit e_first, output bit e_last);
    @(negedge clk);
    a_r[m] = addr; t_r[m] = 2'b10; w_r[m] = wr; s_r[m] = sz;
    @(negedge clk);
    t_r[m] = 2'b00; d_r[m] = wd;
    waits = 0; e_first = 1'b0;
    while (!hready[m]) begin
      if (waits == 0) e_first = hresp[m];
      waits++;
      @(negedge clk);
    end
    rd = hrdata[m*32 +: 32];
    e_last = hresp[m];
  endtask

  task automatic wr_ok(input int m, input logic [31:0] addr, input logic [31:0] wd, input string req);
    logic [31:0] rd; int w; bit ef, el;
    xfer(m, addr, 1'b1, 3'd2, wd, rd, w, ef, el);
    check(!el && !ef, req, "write response", {31'd0, el}, 32'd0);
  endtask

  task automatic rd_chk(input int m, input logic [31:0] addr, input logic [31:0] exp, input string req);
    logic [31:0] rd; int w; bit ef, el;
    xfer(m, addr, 1'b0, 3'd2, 32'd0, rd, w, ef, el);
    check(!el && rd == exp, req, "read data", rd, exp);
  endtask

  task automatic err_chk(input int m, input logic [31:0] addr, input logic [2:0] sz, input string req);
    logic [31:0] rd; int w; bit ef, el;
    xfer(m, addr, 1'b1, sz, 32'hDEAD_BEEF, rd, w, ef, el);
    check(ef && el && w == 1, req, "two-cycle error", {ef, el, 30'(w)}, {2'b11, 30'd1});
  endtask

  task automatic t_reset();
    check(hready == 4'hF && hresp == 4'h0, "R1", "reset outputs", {hready, hresp}, {4'hF, 4'h0});
  endtask

  task automatic t_map();
    logic [31:0] rd; int w; bit ef, el;
    wr_ok(3, B + 32'h0FC, 32'hB0B0_00FC, "R2");
    wr_ok(3, B + 32'h100, 32'hB1B1_0100, "R2");
    wr_ok(3, B + 32'h180, 32'hB2B2_0180, "R2");
    wr_ok(3, B + 32'h1FC, 32'hB2B2_01FC, "R2");
    rd_chk(3, B + 32'h0FC, 32'hB0B0_00FC, "R2");
    rd_chk(3, B + 32'h100, 32'hB1B1_0100, "R2");
    rd_chk(3, B + 32'h180, 32'hB2B2_0180, "R2");
    xfer(3, B + 32'h1FC, 1'b0, 3'd2, 32'd0, rd, w, ef, el);
    check(rd == 32'hB2B2_01FC, "R2", "last word", rd, 32'hB2B2_01FC);
    check(w == 1, "R5", "solo wait states", 32'(w), 32'd1);
    check(!el, "R10", "okay response", {31'd0, el}, 32'd0);
  endtask

  task automatic t_paths();
    wr_ok(0, B + 32'h010, 32'h0000_C0DE, "R3");
    rd_chk(1, B + 32'h010, 32'h0000_C0DE, "R3");
    wr_ok(2, B + 32'h120, 32'h5151_0120, "R3");
    wr_ok(2, B + 32'h1A0, 32'h5252_01A0, "R3");
    rd_chk(3, B + 32'h1A0, 32'h5252_01A0, "R3");
  endtask

  task automatic t_deny();
    err_chk(0, B + 32'h120, 3'd2, "R4");
    err_chk(1, B + 32'h1A0, 3'd2, "R4");
    err_chk(2, B + 32'h010, 3'd2, "R4");
    rd_chk(3, B + 32'h120, 32'h5151_0120, "R3");
    rd_chk(3, B + 32'h1A0, 32'h5252_01A0, "R3");
    rd_chk(3, B + 32'h010, 32'h0000_C0DE, "R3");
  endtask

  task automatic t_range();
    err_chk(3, B + 32'h200, 3'd2, "R4");
    err_chk(3, B - 32'd4, 3'd2, "R4");
    err_chk(3, B + 32'h020, 3'd3, "R4");
  endtask

  task automatic t_parallel();
    logic [31:0] r0, r2, r3; int w0, w2, w3; bit f0, f2, f3, l0, l2, l3;
    fork
      xfer(0, B + 32'h030, 1'b1, 3'd2, 32'hAAAA_0030, r0, w0, f0, l0);
      xfer(2, B + 32'h130, 1'b1, 3'd2, 32'hBBBB_0130, r2, w2, f2, l2);
      xfer(3, B + 32'h1B0, 1'b1, 3'd2, 32'hCCCC_01B0, r3, w3, f3, l3);
    join
    check(w0 == 1 && w2 == 1 && w3 == 1, "R6", "parallel waits",
          {8'(w0), 8'(w2), 8'(w3), 8'd0}, 32'h0101_0100);
    rd_chk(3, B + 32'h030, 32'hAAAA_0030, "R6");
    rd_chk(3, B + 32'h130, 32'hBBBB_0130, "R6");
    rd_chk(3, B + 32'h1B0, 32'hCCCC_01B0, "R6");
  endtask

  task automatic t_rr();
    logic [31:0] r0, r1, r3; int w0, w1, w3; bit f0, f1, f3, l0, l1, l3;
    rd_chk(1, B + 32'h010, 32'h0000_C0DE, "R7");
    fork
      xfer(0, B + 32'h050, 1'b1, 3'd2, 32'h0000_0A50, r0, w0, f0, l0);
      xfer(1, B + 32'h054, 1'b1, 3'd2, 32'h0000_1A54, r1, w1, f1, l1);
      xfer(3, B + 32'h058, 1'b1, 3'd2, 32'h0000_3A58, r3, w3, f3, l3);
    join
    check(w3 == 1, "R7", "first turn master 3", 32'(w3), 32'd1);
    check(w0 == 2, "R7", "second turn master 0", 32'(w0), 32'd2);
    check(w1 == 3, "R8", "stalled until grant master 1", 32'(w1), 32'd3);
    rd_chk(3, B + 32'h050, 32'h0000_0A50, "R8");
    rd_chk(3, B + 32'h054, 32'h0000_1A54, "R8");
    rd_chk(3, B + 32'h058, 32'h0000_3A58, "R8");
  endtask

  task automatic t_lanes();
    logic [31:0] rd; int w; bit ef, el;
    wr_ok(3, B + 32'h040, 32'h1122_3344, "R9");
    xfer(3, B + 32'h042, 1'b1, 3'd0, 32'h00AA_0000, rd, w, ef, el);
    rd_chk(3, B + 32'h040, 32'h11AA_3344, "R9");
    xfer(3, B + 32'h040, 1'b1, 3'd1, 32'h0000_BEEF, rd, w, ef, el);
    rd_chk(3, B + 32'h040, 32'h11AA_BEEF, "R9");
    xfer(0, B + 32'h043, 1'b1, 3'd0, 32'h7700_0000, rd, w, ef, el);
    rd_chk(1, B + 32'h040, 32'h77AA_BEEF, "R10");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      a_r[i] = '0; t_r[i] = '0; w_r[i] = 1'b0; s_r[i] = 3'd2; d_r[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_paths();
    t_deny();
    t_range();
    t_parallel();
    t_rr();
    t_lanes();
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule